// File: doc/BRIEF.md
# Serial-Attached 8-Bit I/O Port Controller with Change Interrupt

This block is the register side of a small general-purpose I/O port that sits behind a byte-oriented serial transaction engine. The engine tells the block when a write transaction begins, hands over every data byte it receives, and asks for a byte whenever the host reads. Inside the block, four registers are reached through a command pointer. The first is a read-only view of the pins. The second holds the output values. The third holds per-bit polarity inversion for the pin view. The fourth sets the direction of each pin.

The first data byte of every write transaction loads the pointer. Later bytes of the same transaction, and every later read, go to the register the pointer selects. The pointer does not advance on its own. Pin levels pass through a synchronizer. The block compares them, bit by bit, with a snapshot taken at the last read of the input register. Any difference on a pin configured as an input pulls the interrupt line low. The line is modelled as open-drain: an active-low level plus a drive enable.

Top module: `gpx_port`

## Requirements
- R1: While reset is active and right after it ends, the output register reads 0xFF, the polarity register reads 0x00 and the direction register reads 0xFF. Also: every `pin_oe` bit is 0, `pin_out` is 0x00, `irq_oe` is 0, `irq_n` is 1 and `bus_rd_data` is 0x00.
- R2: The first byte written after `bus_start` loads the pointer. Pointer code 0 selects the input view, 1 the output register, 2 the polarity register and 3 the direction register. A byte presented in the same cycle as `bus_start` is itself that first byte.
- R3: The pointer keeps its value across any number of later data bytes and reads. Two data bytes written under pointer 1 leave the second byte in the output register, and the neighbouring registers are untouched.
- R4: A read under pointer 0 returns the synchronized pin levels, whatever direction each pin has. A read request presented two cycles after a pin change returns the new level; one presented a single cycle after returns the old level. Data bytes written under pointer 0 change no register.
- R5: Each bit of the input view is inverted when the matching polarity bit is 1 and passed unchanged when it is 0.
- R6: A read under pointer 1 returns the stored output value, not the level on the pins.
- R7: Direction bit 1 makes a pin an input: its `pin_oe` bit is 0 and its `pin_out` bit is 0. Direction bit 0 makes it an output: `pin_oe` is 1 and `pin_out` carries the output register bit.
- R8: A pointer above 3 reads as 0x00, and data bytes written under it change no register.
- R9: A level change on an input pin activates the interrupt on the third clock edge after the change. A change on an output pin never activates it.
- R10: The interrupt deactivates on its own on the third clock edge after the pin returns to its snapshot level.
- R11: A read under pointer 0 deactivates the interrupt on the edge that accepts the request. The same edge refreshes the snapshot, so the interrupt stays inactive while the pins hold.
- R12: Turning a pin from output to input activates the interrupt one edge after the direction write if the pin differs from the snapshot. Nothing masks this.
- R13: `irq_oe` is 1 exactly when `irq_n` is 0.
- R14: `bus_rd_data` takes its new value on the edge that accepts `bus_rd_req` and holds it until the next request, even if the pins change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_start | input | 1 | One-cycle pulse: a write transaction has begun |
| bus_wr_valid | input | 1 | One-cycle pulse: `bus_wr_data` holds a received byte |
| bus_wr_data | input | 8 | Received byte |
| bus_rd_req | input | 1 | One-cycle pulse: the host is reading a byte |
| bus_rd_data | output | 8 | Byte to send, valid from the edge that accepts the request |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Output values; 0 on input pins |
| pin_oe | output | 8 | Output driver enables, 1 = drive |
| irq_n | output | 1 | Interrupt level, active low |
| irq_oe | output | 1 | Interrupt drive enable (open-drain model) |

## Verification
Each result has a fixed delay. Register writes show up on `pin_out` and `pin_oe` one edge after the data byte. Read data is due one edge after the request. A pin change reaches the input view after two edges and the interrupt after three. A direction change reaches the interrupt after one edge beyond the write. The bench drives every stimulus at a falling edge and counts whole cycles to the falling edge where the result must be present. Wherever an exact delay is stated, it also checks the cycle before, where the old value must still be seen. Polarity, pin levels and direction are each swept over all 256 values, and the interrupt is exercised on every bit.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int unsigned PTR_W = 8;

  typedef enum logic [1:0] {
    SEL_IN  = 2'd0,
    SEL_OUT = 2'd1,
    SEL_POL = 2'd2,
    SEL_DIR = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_SEL = 4;
endpackage

// File: rtl/gpx_rst_sync.sv
module gpx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_valid,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_req,
  input  logic [W-1:0]     pin_lvl,
  output logic [W-1:0]     rd_data,
  output logic [W-1:0]     out_q,
  output logic [W-1:0]     pol_q,
  output logic [W-1:0]     dir_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic             expect_q,
  output logic             snap
);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(NUM_SEL - 1);

  logic             cmd_phase, expect_d;
  logic [PTR_W-1:0] ptr_d;
  logic [W-1:0]     out_d, pol_d, dir_d, rd_d, in_view;
  logic             data_wr;

  assign cmd_phase = expect_q | start;
  assign data_wr   = wr_valid & ~cmd_phase;
  assign in_view   = pin_lvl ^ pol_q;
  assign snap      = rd_req && (ptr_q == PTR_W'(SEL_IN));

  always_comb begin
    expect_d = expect_q;
    if (start)                 expect_d = 1'b1;
    if (wr_valid && cmd_phase) expect_d = 1'b0;

    ptr_d = ptr_q;
    if (wr_valid && cmd_phase) ptr_d = PTR_W'(wr_data);

    out_d = out_q;
    pol_d = pol_q;
    dir_d = dir_q;
    if (data_wr && ptr_q <= PTR_MAX) begin
      case (reg_sel_e'(ptr_q[1:0]))
        SEL_OUT: out_d = wr_data;
        SEL_POL: pol_d = wr_data;
        SEL_DIR: dir_d = wr_data;
        default: ;
      endcase
    end

    rd_d = '0;
    if (ptr_q <= PTR_MAX) begin
      case (reg_sel_e'(ptr_q[1:0]))
        SEL_IN:  rd_d = in_view;
        SEL_OUT: rd_d = out_q;
        SEL_POL: rd_d = pol_q;
        SEL_DIR: rd_d = dir_q;
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_q <= 1'b0;
      ptr_q    <= '0;
      out_q    <= '1;
      pol_q    <= '0;
      dir_q    <= '1;
    end else begin
      expect_q <= expect_d;
      ptr_q    <= ptr_d;
      out_q    <= out_d;
      pol_q    <= pol_d;
      dir_q    <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_req) rd_data <= rd_d;
  end
endmodule

// File: rtl/gpx_irq.sv
module gpx_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] dir,
  input  logic         snap,
  output logic         irq_q
);
  logic [W-1:0] ref_q;
  logic         irq_d;

  assign irq_d = ~snap & (|((lvl ^ ref_q) & dir));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ref_q <= '1;
    else if (snap) ref_q <= lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/gpx_port.sv
module gpx_port
  import gpx_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_wr_valid,
  input  logic [PORT_W-1:0] bus_wr_data,
  input  logic              bus_rd_req,
  output logic [PORT_W-1:0] bus_rd_data,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic              irq_n,
  output logic              irq_oe
);
  logic              rst_n_s;
  logic [PORT_W-1:0] lvl_s, out_q, pol_q, dir_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              expect_q, snap, irq_q;

  gpx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_s)
  );

  gpx_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .din(pin_in), .dout(lvl_s)
  );

  gpx_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .start(bus_start), .wr_valid(bus_wr_valid),
    .wr_data(bus_wr_data), .rd_req(bus_rd_req), .pin_lvl(lvl_s),
    .rd_data(bus_rd_data), .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q),
    .ptr_q(ptr_q), .expect_q(expect_q), .snap(snap)
  );

  gpx_irq #(.W(PORT_W)) u_irq (
    .clk(clk), .rst_n(rst_n_s), .lvl(lvl_s), .dir(dir_q), .snap(snap),
    .irq_q(irq_q)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = out_q & ~dir_q;
  assign irq_n   = ~irq_q;
  assign irq_oe  = irq_q;
endmodule

// File: rtl/gpx_port_chk.sv
module gpx_port_chk
  import gpx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             wr_valid,
  input logic [W-1:0]     wr_data,
  input logic             rd_req,
  input logic [PTR_W-1:0] ptr,
  input logic             expect_cmd,
  input logic [W-1:0]     out_q,
  input logic [W-1:0]     pol_q,
  input logic [W-1:0]     dir_q,
  input logic [W-1:0]     pin_out,
  input logic [W-1:0]     pin_oe,
  input logic             irq_n,
  input logic             irq_oe
);
  // R2
  cmd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (expect_cmd || start)) |=> (ptr == PTR_W'($past(wr_data))));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !expect_cmd && !start) |=> $stable(ptr));

  // R4 R8
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !expect_cmd && !start && (ptr == '0 || ptr > PTR_W'(3)))
      |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

  // R7
  input_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));

  // R11
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ptr == '0) |=> !irq_oe);

  // R13
  irq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe == !irq_n));
endmodule

bind gpx_port gpx_port_chk #(.W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .start(bus_start), .wr_valid(bus_wr_valid),
  .wr_data(bus_wr_data), .rd_req(bus_rd_req), .ptr(ptr_q),
  .expect_cmd(expect_q), .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n), .irq_oe(irq_oe)
);

// File: tb/test_gpx_port.sv
`timescale 1ns/1ps
module test_gpx_port;
  logic       clk = 1'b0;
  logic       rst_n, start, wr_valid, rd_req;
  logic [7:0] wr_data, pins, rd_data, pin_out, pin_oe;
  logic       irq_n, irq_oe;
  int checks = 0, fails = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  gpx_port i_gpx_port (
    .clk(clk), .rst_n(rst_n), .bus_start(start), .bus_wr_valid(wr_valid),
    .bus_wr_data(wr_data), .bus_rd_req(rd_req), .bus_rd_data(rd_data),
    .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n),
    .irq_oe(irq_oe)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(string tag, bit active);
    chk(tag, {6'd0, irq_oe, irq_n}, active ? 8'h02 : 8'h01);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ptr(logic [7:0] p);
    start = 1'b1; wr_valid = 1'b1; wr_data = p;
    tick(1);
    start = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic wr_reg(logic [7:0] p, logic [7:0] d);
    set_ptr(p);
    wr_valid = 1'b1; wr_data = d;
    tick(1);
    wr_valid = 1'b0;
  endtask

  task automatic rd(output logic [7:0] r);
    rd_req = 1'b1;
    tick(1);
    rd_req = 1'b0;
    r = rd_data;
  endtask

  task automatic rd_reg(logic [7:0] p, output logic [7:0] r);
    set_ptr(p);
    rd(r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_valid = 1'b0; rd_req = 1'b0;
    wr_data = 8'h00; pins = 8'hFF;
    tick(3);
    // R1 during reset
    chk("R1 rd_data in reset", rd_data, 8'h00);
    chk("R1 pin_oe in reset", pin_oe, 8'h00);
    chk_irq("R1 irq in reset", 1'b0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk_irq("R1 irq", 1'b0);
    chk("R1 rd_data", rd_data, 8'h00);
    rd_reg(8'd1, v); chk("R1 out reg", v, 8'hFF);
    rd_reg(8'd2, v); chk("R1 pol reg", v, 8'h00);
    rd_reg(8'd3, v); chk("R1 dir reg", v, 8'hFF);

    // R2 byte in the start cycle is the pointer; R6 output read ignores pins
    wr_reg(8'd1, 8'h3C);
    pins = 8'hC3;
    tick(3);
    rd_reg(8'd1, v); chk("R2 R6 out reg", v, 8'h3C);
    rd_reg(8'd0, v); chk("R2 R4 input view", v, 8'hC3);

    // R7 direction sweep with pin output checks
    for (int d = 0; d < 256; d++) begin
      wr_reg(8'd3, 8'(d));
      chk("R7 pin_oe", pin_oe, ~8'(d));
      chk("R7 pin_out", pin_out, 8'h3C & ~8'(d));
    end
    rd_reg(8'd3, v); chk("R2 dir readback", v, 8'hFF);

    // R5 polarity sweep
    for (int p = 0; p < 256; p++) begin
      wr_reg(8'd2, 8'(p));
      pins = 8'(p * 53 + 17);
      tick(2);
      rd_reg(8'd0, v);
      chk("R5 polarity", v, 8'(p * 53 + 17) ^ 8'(p));
    end

    // R4 pin sweep at fixed polarity, direction all outputs
    wr_reg(8'd2, 8'hA5);
    wr_reg(8'd3, 8'h00);
    set_ptr(8'd0);
    for (int q = 0; q < 256; q++) begin
      pins = 8'(q);
      tick(2);
      rd(v);
      chk("R4 pin sweep", v, 8'(q) ^ 8'hA5);
    end
    // R4 sync latency: one cycle is too early, two is enough
    pins = 8'h0F;
    tick(2);
    rd(v);
    pins = 8'hF0;
    tick(1);
    rd(v); chk("R4 one-cycle old level", v, 8'h0F ^ 8'hA5);
    tick(1);
    pins = 8'h5A;
    tick(2);
    rd(v); chk("R4 two-cycle new level", v, 8'h5A ^ 8'hA5);
    // R14 read data holds while pins change
    pins = 8'h00;
    tick(3);
    chk("R14 rd_data hold", rd_data, 8'h5A ^ 8'hA5);

    // R4 writes under pointer 0 ignored
    wr_reg(8'd0, 8'h00);
    chk("R4 ptr0 write pin_oe", pin_oe, 8'hFF);
    rd_reg(8'd1, v); chk("R4 ptr0 write out", v, 8'h3C);
    rd_reg(8'd2, v); chk("R4 ptr0 write pol", v, 8'hA5);
    rd_reg(8'd3, v); chk("R4 ptr0 write dir", v, 8'h00);

    // R8 pointer above 3
    wr_reg(8'd7, 8'h99);
    rd_reg(8'd7, v); chk("R8 high ptr read", v, 8'h00);
    rd_reg(8'd1, v); chk("R8 out kept", v, 8'h3C);
    rd_reg(8'd2, v); chk("R8 pol kept", v, 8'hA5);
    rd_reg(8'd3, v); chk("R8 dir kept", v, 8'h00);

    // R3 no auto-increment
    set_ptr(8'd1);
    wr_valid = 1'b1; wr_data = 8'h11; tick(1);
    wr_data = 8'h22; tick(1);
    wr_valid = 1'b0;
    rd(v); chk("R3 last byte kept", v, 8'h22);
    rd(v); chk("R3 pointer held", v, 8'h22);
    rd_reg(8'd2, v); chk("R3 neighbour untouched", v, 8'hA5);

    // R9 R10 R11 interrupt per bit, all inputs
    wr_reg(8'd3, 8'hFF);
    wr_reg(8'd2, 8'h00);
    pins = 8'h00;
    tick(2);
    rd_reg(8'd0, v);
    tick(3);
    chk_irq("R9 idle", 1'b0);
    for (int b = 0; b < 8; b++) begin
      pins = 8'h01 << b;
      tick(2); chk_irq("R9 before third edge", 1'b0);
      tick(1); chk_irq("R9 asserted", 1'b1);
      pins = 8'h00;
      tick(2); chk_irq("R10 still active", 1'b1);
      tick(1); chk_irq("R10 released", 1'b0);
      pins = 8'h01 << b;
      tick(3); chk_irq("R11 pre-read", 1'b1);
      rd(v);   chk_irq("R11 cleared by read", 1'b0);
      chk("R11 read value", v, 8'h01 << b);
      tick(3); chk_irq("R11 stays clear", 1'b0);
      pins = 8'h00;
      tick(2);
      rd(v);
      tick(2); chk_irq("R11 resync", 1'b0);
    end

    // R9 output pin change raises nothing; R12 spurious on turn to input
    wr_reg(8'd3, 8'hFE);
    tick(2);
    pins = 8'h01;
    tick(4); chk_irq("R9 output pin no irq", 1'b0);
    wr_reg(8'd3, 8'hFF);
    chk_irq("R12 not yet", 1'b0);
    tick(1); chk_irq("R12 spurious irq", 1'b1);
    rd_reg(8'd0, v); chk_irq("R12 cleared", 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule